// File: doc/BRIEF.md
# Bus-Slave Control and Status Port

This block is the slave-side register file that a processor board presents on a shared system bus through I/O commands. The bus offers active-low I/O read and write strobes, an 8-bit I/O address and a byte of write data. The block decodes each command against a base value set by board straps. It serves three ports: an identification byte, a status byte and a control byte. It answers every access it claims with an active-low transfer acknowledge, and ignores every access it does not claim.

The control byte governs the on-board processor. Writing a parameterised initialization pattern holds the processor in initialization, and so does the bus's system-initialize line. Any other value written there releases it. The identification byte always answers at I/O address 00H, whatever base is strapped. The status byte reports three configuration straps and the current initialization state.

A separate board interrupt is routed to exactly one of three active-low request lines, chosen by a strap.

Top module: `ioport_slave`

## Requirements
- R1: An access to a status or control port is claimed only when address bits 7:4 equal the strapped base (`base_sel` 1 to 7; a value of 0 acts as 1) and bits 3:0 equal the port offset (status 2, control 4). Any other upper nibble gets no acknowledge.
- R2: A read of address 00H returns `ID_VALUE` (default 5CH) for every base setting.
- R3: An access to an odd address is never acknowledged and has no effect on the control byte or on `proc_init`.
- R4: A status read returns `cfg_strap[2:0]` on data bits 7:5 (1 = strap fitted), `proc_init` on bit 4 and zero on bits 3:0.
- R5: A control write of `INIT_PATTERN` (default 96H) sets `proc_init`, and a write of any other value clears it. The change takes effect at the clock edge that raises the acknowledge. A control read returns the last byte written, which is 96H after reset.
- R6: While `sys_init_n` is low, `proc_init` is set at the next edge and the control byte becomes `INIT_PATTERN`. `proc_init` then stays set until a control write of another value.
- R7: After reset, `io_xack_n` is 1, `proc_init` is 1, `int_req_n` is 111 and `io_rdata` is 0.
- R8: The acknowledge falls at the `ACK_DELAY`-th rising edge (default 2), counted from the first edge that samples a claimed command. It stays low while the strobe stays low and rises at the first edge that sees both strobes high. A command removed before the acknowledge gets no acknowledge and no write.
- R9: When `board_irq` is high, exactly one `int_req_n` bit is low one edge later. `irq_sel` picks the bit: 0 or 3 picks bit 0, 1 picks bit 1 and 2 picks bit 2. With `board_irq` low, all bits are high.
- R10: `io_rdata` is zero whenever the acknowledge is high and during a write acknowledge.
- R11: A cycle with both strobes low is not a command and never starts an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-synchronous clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_rd_n | input | 1 | I/O read strobe, active low |
| io_wr_n | input | 1 | I/O write strobe, active low |
| io_addr | input | 8 | I/O address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while acknowledged |
| io_xack_n | output | 1 | Transfer acknowledge, active low |
| sys_init_n | input | 1 | System initialize, active low |
| base_sel | input | 3 | Strapped base nibble |
| cfg_strap | input | 3 | Configuration straps reported in status |
| irq_sel | input | 2 | Strap choosing the interrupt request line |
| board_irq | input | 1 | Board interrupt source, active high |
| proc_init | output | 1 | Holds the processor in initialization |
| int_req_n | output | 3 | Interrupt request lines, active low |

## Verification
Some properties are checked by the assertions on every cycle:
- the acknowledge is low only after a strobe, holds with the strobe and releases once the strobes are gone;
- a double strobe never starts one;
- an odd address is never acknowledged;
- system initialize forces `proc_init`, which then holds without a write;
- at most one request line is active, and one is active after `board_irq`.

Other properties need the bench's scenarios:
- the exact acknowledge latency;
- the data returned by each port under several base and strap settings;
- the pattern-versus-other-value decode of control writes;
- a command aborted mid-wait;
- the line chosen for each `irq_sel` value.

// File: rtl/ioport_pkg.sv
// Shared types for the bus-slave control and status port.
// Assumes an 8-bit data path; address width is set by the top module.
package ioport_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_WAIT = 2'd1,
        HS_ACK  = 2'd2
    } hs_state_e;

    typedef struct packed {
        logic id;
        logic stat;
        logic ctrl;
    } port_sel_t;
endpackage

// File: rtl/ioport_decode.sv
// Address decoder: turns the I/O address and the strapped base into one-hot
// port selects. Assumes the address is stable for the whole command.
module ioport_decode
    import ioport_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int STAT_OFS = 2,
    parameter int CTRL_OFS = 4,
    localparam int NIB     = ADDR_W / 2
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [NIB-2:0]    base_sel,
    output port_sel_t         sel,
    output logic              hit
);
    logic [NIB-2:0] base_eff;
    logic           base_ok;
    logic           even;

    // A strap value of zero falls back to the lowest legal base.
    always_comb base_eff = (base_sel == '0) ? (NIB-1)'(1) : base_sel;

    // Match the upper nibble against the base and the lower nibble per port.
    always_comb begin
        base_ok  = (io_addr[ADDR_W-1:NIB] == {1'b0, base_eff});
        even     = ~io_addr[0];
        sel.id   = (io_addr == '0);
        sel.stat = even && base_ok && (io_addr[NIB-1:0] == NIB'(STAT_OFS));
        sel.ctrl = even && base_ok && (io_addr[NIB-1:0] == NIB'(CTRL_OFS));
        hit      = sel.id | sel.stat | sel.ctrl;
    end
endmodule

// File: rtl/ioport_handshake.sv
// Command handshake: waits ACK_DELAY edges after a claimed strobe, raises the
// acknowledge until both strobes are released, and emits a one-cycle fire
// pulse for the register file. Assumes strobes are synchronous to clk.
module ioport_handshake
    import ioport_pkg::*;
#(
    parameter int ACK_DELAY = 2,
    localparam int CW       = $clog2(ACK_DELAY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic io_rd_n,
    input  logic io_wr_n,
    input  logic hit,
    output logic xack_n,
    output logic fire_rd,
    output logic fire_wr
);
    hs_state_e       state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic            cmd_rd, cmd_wr, cmd_any, cmd_none, fire;

    // Classify the strobes; both low together is not a command.
    always_comb begin
        cmd_rd   = ~io_rd_n & io_wr_n;
        cmd_wr   = ~io_wr_n & io_rd_n;
        cmd_any  = cmd_rd | cmd_wr;
        cmd_none = io_rd_n & io_wr_n;
    end

    // Next-state logic for the wait counter and acknowledge.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire    = 1'b0;
        unique case (state_q)
            HS_IDLE: if (cmd_any && hit) begin
                if (ACK_DELAY <= 1) begin
                    state_d = HS_ACK;
                    fire    = 1'b1;
                end else begin
                    state_d = HS_WAIT;
                    cnt_d   = CW'(1);
                end
            end
            HS_WAIT: if (!cmd_any) begin
                state_d = HS_IDLE;
            end else if (cnt_q >= CW'(ACK_DELAY - 1)) begin
                state_d = HS_ACK;
                fire    = 1'b1;
            end else begin
                cnt_d = cnt_q + CW'(1);
            end
            HS_ACK:  if (cmd_none) state_d = HS_IDLE;
            default: state_d = HS_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs decoded from state and the transition pulse.
    always_comb begin
        xack_n  = (state_q != HS_ACK);
        fire_rd = fire & cmd_rd;
        fire_wr = fire & cmd_wr;
    end

    assert_ack_needs_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !xack_n |-> $past(!io_rd_n || !io_wr_n));
    assert_ack_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!xack_n && !(io_rd_n && io_wr_n)) |=> !xack_n);
    assert_ack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!xack_n && io_rd_n && io_wr_n) |=> xack_n);
    assert_no_ack_double_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (xack_n && !io_rd_n && !io_wr_n) |=> xack_n);
endmodule

// File: rtl/ioport_regs.sv
// Register file: identification, status and control ports plus the
// processor-init flag. Acts on the fire pulses from the handshake.
module ioport_regs
    import ioport_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_VALUE     = 8'h5C,
    parameter logic [DATA_W-1:0] INIT_PATTERN = 8'h96,
    parameter int                NUM_STRAP    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  port_sel_t            sel,
    input  logic                 fire_rd,
    input  logic                 fire_wr,
    input  logic                 xack_n,
    input  logic                 sys_init_n,
    input  logic [DATA_W-1:0]    io_wdata,
    input  logic [NUM_STRAP-1:0] cfg_strap,
    output logic [DATA_W-1:0]    io_rdata,
    output logic                 proc_init
);
    logic [DATA_W-1:0] ctrl_q, stat_w, mux_w, rdata_q;

    // Assemble the status byte: straps on top, init flag below them.
    always_comb begin
        stat_w = '0;
        stat_w[DATA_W-1 -: NUM_STRAP] = cfg_strap;
        stat_w[DATA_W-1-NUM_STRAP]    = proc_init;
    end

    // Select read data for the addressed port.
    always_comb begin
        mux_w = '0;
        if (sel.id)   mux_w = ID_VALUE;
        if (sel.stat) mux_w = stat_w;
        if (sel.ctrl) mux_w = ctrl_q;
    end

    // Control byte and init flag; system initialize has priority.
    always_ff @(posedge clk) begin
        if (!rst_n || !sys_init_n) begin
            ctrl_q    <= INIT_PATTERN;
            proc_init <= 1'b1;
        end else if (fire_wr && sel.ctrl) begin
            ctrl_q    <= io_wdata;
            proc_init <= (io_wdata == INIT_PATTERN);
        end
    end

    // Capture read data when an acknowledge starts; writes capture zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                   rdata_q <= '0;
        else if (fire_rd || fire_wr)  rdata_q <= fire_rd ? mux_w : '0;
    end

    // Drive read data only while acknowledged.
    always_comb io_rdata = xack_n ? '0 : rdata_q;

    assert_sysinit_forces_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_init_n |=> proc_init);
    assert_init_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_init && !fire_wr) |=> proc_init);
endmodule

// File: rtl/ioport_irq_route.sv
// Interrupt router: drives the board interrupt onto one of NUM_IRQ
// active-low request lines chosen by a strap; out-of-range picks line 0.
module ioport_irq_route #(
    parameter int NUM_IRQ = 3,
    localparam int SEL_W  = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               board_irq,
    input  logic [SEL_W-1:0]   irq_sel,
    output logic [NUM_IRQ-1:0] int_req_n
);
    logic [SEL_W-1:0] sel_eff;

    // Fold illegal selections onto the lowest line.
    always_comb sel_eff = (irq_sel >= SEL_W'(NUM_IRQ)) ? '0 : irq_sel;

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
        // Register each request line.
        always_ff @(posedge clk) begin
            if (!rst_n) int_req_n[g] <= 1'b1;
            else        int_req_n[g] <= ~(board_irq && (sel_eff == SEL_W'(g)));
        end
    end

    assert_one_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~int_req_n));
    assert_irq_driven_R9: assert property (@(posedge clk) disable iff (!rst_n)
        board_irq |=> !(&int_req_n));
endmodule

// File: rtl/ioport_slave.sv
// Top of the bus-slave control and status port. Wires decoder, handshake,
// register file and interrupt router. Assumes synchronous bus strobes and an
// address held stable for the length of each command.
module ioport_slave
    import ioport_pkg::*;
#(
    parameter int                ADDR_W       = 8,
    parameter int                ACK_DELAY    = 2,
    parameter logic [DATA_W-1:0] ID_VALUE     = 8'h5C,
    parameter logic [DATA_W-1:0] INIT_PATTERN = 8'h96,
    parameter int                STAT_OFS     = 2,
    parameter int                CTRL_OFS     = 4,
    parameter int                NUM_STRAP    = 3,
    parameter int                NUM_IRQ      = 3,
    localparam int               NIB          = ADDR_W / 2,
    localparam int               SEL_W        = $clog2(NUM_IRQ)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 io_rd_n,
    input  logic                 io_wr_n,
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic [DATA_W-1:0]    io_wdata,
    output logic [DATA_W-1:0]    io_rdata,
    output logic                 io_xack_n,
    input  logic                 sys_init_n,
    input  logic [NIB-2:0]       base_sel,
    input  logic [NUM_STRAP-1:0] cfg_strap,
    input  logic [SEL_W-1:0]     irq_sel,
    input  logic                 board_irq,
    output logic                 proc_init,
    output logic [NUM_IRQ-1:0]   int_req_n
);
    port_sel_t sel;
    logic      hit, fire_rd, fire_wr;

    ioport_decode #(.ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .CTRL_OFS(CTRL_OFS)) u_dec (
        .io_addr(io_addr), .base_sel(base_sel), .sel(sel), .hit(hit));

    ioport_handshake #(.ACK_DELAY(ACK_DELAY)) u_hs (
        .clk(clk), .rst_n(rst_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .hit(hit),
        .xack_n(io_xack_n), .fire_rd(fire_rd), .fire_wr(fire_wr));

    ioport_regs #(.ID_VALUE(ID_VALUE), .INIT_PATTERN(INIT_PATTERN), .NUM_STRAP(NUM_STRAP)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(sel), .fire_rd(fire_rd), .fire_wr(fire_wr),
        .xack_n(io_xack_n), .sys_init_n(sys_init_n), .io_wdata(io_wdata),
        .cfg_strap(cfg_strap), .io_rdata(io_rdata), .proc_init(proc_init));

    ioport_irq_route #(.NUM_IRQ(NUM_IRQ)) u_irq (
        .clk(clk), .rst_n(rst_n), .board_irq(board_irq), .irq_sel(irq_sel),
        .int_req_n(int_req_n));

    assert_odd_no_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !io_xack_n |-> !$past(io_addr[0]));
endmodule

// File: tb/ioport_slave_tb_top.sv
module ioport_slave_tb_top;
    localparam int ACK_DELAY = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_rd_n = 1'b1, io_wr_n = 1'b1;
    logic [7:0] io_addr = '0, io_wdata = '0;
    logic [7:0] io_rdata;
    logic       io_xack_n, proc_init;
    logic       sys_init_n = 1'b1;
    logic [2:0] base_sel = 3'd0, cfg_strap = 3'b101;
    logic [1:0] irq_sel = 2'd0;
    logic       board_irq = 1'b0;
    logic [2:0] int_req_n;

    int tests = 0, fails = 0;
    bit done = 0;

    typedef struct {
        bit         is_rd;
        logic [7:0] exp;
        string      tag;
    } exp_t;
    exp_t sbq[$];

    always #10 clk = ~clk;

    ioport_slave dut_i (
        .clk(clk), .rst_n(rst_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .io_xack_n(io_xack_n), .sys_init_n(sys_init_n), .base_sel(base_sel),
        .cfg_strap(cfg_strap), .irq_sel(irq_sel), .board_irq(board_irq),
        .proc_init(proc_init), .int_req_n(int_req_n));

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] stat_exp(logic [2:0] s, logic pi);
        return {s, pi, 4'b0000};
    endfunction

    // Monitor: pops one expected item per acknowledge and compares read data.
    initial begin
        forever begin
            exp_t e;
            @(negedge io_xack_n);
            #2;
            if (sbq.size() == 0) chk(0, "R8", "unexpected ack", 0, 1);
            else begin
                e = sbq.pop_front();
                if (e.is_rd) chk(io_rdata == e.exp, e.tag, "read data", io_rdata, e.exp);
                else         chk(io_rdata == 8'h00, "R10", "rdata in write ack", io_rdata, 0);
            end
        end
    end

    // Driver: one bus access, pushing the expectation before the strobe.
    task automatic access(bit is_rd, logic [7:0] a, logic [7:0] d, bit want_ack,
                          logic [7:0] exp, string tag);
        int  waited = 0;
        bit  acked  = 0;
        @(negedge clk);
        io_addr  = a;
        io_wdata = d;
        if (want_ack) sbq.push_back('{is_rd, exp, tag});
        if (is_rd) io_rd_n = 1'b0; else io_wr_n = 1'b0;
        for (int i = 0; i < 8 && !acked; i++) begin
            @(negedge clk);
            waited++;
            if (!io_xack_n) acked = 1;
        end
        if (want_ack) begin
            chk(acked, tag, "ack seen", acked, 1);
            chk(waited == ACK_DELAY, "R8", "ack latency", waited, ACK_DELAY);
        end else begin
            chk(!acked, tag, "no ack expected", acked, 0);
        end
        io_rd_n = 1'b1;
        io_wr_n = 1'b1;
        @(negedge clk);
        if (want_ack) begin
            chk(io_xack_n == 1'b1, "R8", "ack release", io_xack_n, 1);
            chk(io_rdata == 8'h00, "R10", "rdata idle", io_rdata, 0);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            chk(0, "WDOG", "watchdog expired", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        chk(io_xack_n == 1'b1, "R7", "xack after reset", io_xack_n, 1);
        chk(proc_init == 1'b1, "R7", "proc_init after reset", proc_init, 1);
        chk(int_req_n == 3'b111, "R7", "irq lines after reset", int_req_n, 3'b111);
        chk(io_rdata == 8'h00, "R7", "rdata after reset", io_rdata, 0);

        // R1/R4 default base (strap 0 acts as 1), R2 id, R5 ctrl reset value
        access(1, 8'h12, 8'h00, 1, stat_exp(3'b101, 1'b1), "R4");
        access(1, 8'h00, 8'h00, 1, 8'h5C, "R2");
        access(1, 8'h14, 8'h00, 1, 8'h96, "R5");

        // R1 base 5, R2 id still at 00H
        base_sel  = 3'd5;
        cfg_strap = 3'b010;
        access(1, 8'h00, 8'h00, 1, 8'h5C, "R2");
        access(1, 8'h12, 8'h00, 0, 8'h00, "R1");
        access(1, 8'h52, 8'h00, 1, stat_exp(3'b010, 1'b1), "R1");

        // R3 odd addresses
        access(1, 8'h53, 8'h00, 0, 8'h00, "R3");
        access(1, 8'h01, 8'h00, 0, 8'h00, "R3");
        access(0, 8'h55, 8'h00, 0, 8'h00, "R3");
        chk(proc_init == 1'b1, "R3", "odd write ignored", proc_init, 1);

        // R5 control writes
        access(0, 8'h54, 8'h3C, 1, 8'h00, "R5");
        chk(proc_init == 1'b0, "R5", "non-pattern releases", proc_init, 0);
        access(1, 8'h54, 8'h00, 1, 8'h3C, "R5");
        access(1, 8'h52, 8'h00, 1, stat_exp(3'b010, 1'b0), "R4");
        access(0, 8'h54, 8'h96, 1, 8'h00, "R5");
        chk(proc_init == 1'b1, "R5", "pattern holds init", proc_init, 1);
        access(0, 8'h54, 8'h00, 1, 8'h00, "R5");
        chk(proc_init == 1'b0, "R5", "zero releases", proc_init, 0);

        // R8 abort before acknowledge
        @(negedge clk);
        io_addr = 8'h54; io_wdata = 8'h96; io_wr_n = 1'b0;
        @(negedge clk);
        io_wr_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(io_xack_n == 1'b1, "R8", "aborted no ack", io_xack_n, 1);
        end
        chk(proc_init == 1'b0, "R8", "aborted no write", proc_init, 0);

        // R11 both strobes low
        @(negedge clk);
        io_rd_n = 1'b0; io_wr_n = 1'b0;
        repeat (5) begin
            @(negedge clk);
            chk(io_xack_n == 1'b1, "R11", "double strobe no ack", io_xack_n, 1);
        end
        io_rd_n = 1'b1; io_wr_n = 1'b1;
        @(negedge clk);
        chk(proc_init == 1'b0, "R11", "double strobe no write", proc_init, 0);

        // R6 system initialize
        sys_init_n = 1'b0;
        @(negedge clk);
        sys_init_n = 1'b1;
        chk(proc_init == 1'b1, "R6", "sys init sets", proc_init, 1);
        repeat (4) @(negedge clk);
        chk(proc_init == 1'b1, "R6", "init held", proc_init, 1);
        access(1, 8'h54, 8'h00, 1, 8'h96, "R6");
        access(0, 8'h54, 8'h11, 1, 8'h00, "R6");
        chk(proc_init == 1'b0, "R6", "write releases", proc_init, 0);

        // R1 base 7
        base_sel  = 3'd7;
        cfg_strap = 3'b111;
        access(1, 8'h72, 8'h00, 1, stat_exp(3'b111, 1'b0), "R1");
        access(1, 8'hF2, 8'h00, 0, 8'h00, "R1");

        // R9 interrupt routing
        board_irq = 1'b1;
        irq_sel = 2'd0; @(negedge clk);
        chk(int_req_n == 3'b110, "R9", "sel 0", int_req_n, 3'b110);
        irq_sel = 2'd1; @(negedge clk);
        chk(int_req_n == 3'b101, "R9", "sel 1", int_req_n, 3'b101);
        irq_sel = 2'd2; @(negedge clk);
        chk(int_req_n == 3'b011, "R9", "sel 2", int_req_n, 3'b011);
        irq_sel = 2'd3; @(negedge clk);
        chk(int_req_n == 3'b110, "R9", "sel 3 folds to 0", int_req_n, 3'b110);
        board_irq = 1'b0; @(negedge clk);
        chk(int_req_n == 3'b111, "R9", "irq idle", int_req_n, 3'b111);

        repeat (3) @(negedge clk);
        chk(sbq.size() == 0, "R8", "scoreboard drained", sbq.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule